// File: doc/BRIEF.md
# Lockable Four-Way Replacement Way Selector

This block decides which way of a four-way set-associative cache receives a newly allocated line, and whether the line being replaced must be written back first. It keeps its own per-set record of which ways hold valid lines. It also keeps the replacement state for each set: a two-bit rotation pointer used in normal operation and a one-bit toggle used while locked. Tag comparison, the data arrays and the write-back buffer sit outside it.

A single lock input fences off the two lower ways of every set. While it is high, allocation only ever uses the upper pair. It fills way 2 before way 3 and then alternates between them. The fenced ways still take write-hit updates. They lose lines only through explicit invalidate or push commands. Each accepted request produces exactly one response, one cycle later.

Top module: `lock_victim_sel`

## Requirements
- R1: A synchronous active-high reset clears every valid bit and every replacement pointer, and keeps `rsp_vld` low until a request is accepted.
- R2: Each cycle with a request yields `rsp_vld` high on the next cycle and no other. A command takes precedence over a write hit, and a write hit over an allocate; a lower-priority request in the same cycle is dropped with no effect.
- R3: When `lock_en` is low, an allocate picks the lowest-numbered way whose valid bit is clear in the addressed set.
- R4: When `lock_en` is low and all four ways are valid, an allocate picks the way named by that set's rotation pointer. The pointer starts at 0 and advances by one, modulo 4, after each such allocate.
- R5: When `lock_en` is high, an allocate never returns way 0 or way 1.
- R6: When `lock_en` is high, an allocate returns way 2 if way 2 is invalid. It returns way 3 only when way 2 is valid and way 3 is invalid.
- R7: When `lock_en` is high and ways 2 and 3 are both valid, an allocate returns way 2 plus that set's toggle bit. The toggle starts at 0 and flips after each such allocate.
- R8: An allocate response has `rsp_wr_en` = 1 and `rsp_victim` equal to the prior valid bit of the chosen line, and it leaves that line valid.
- R9: A write hit on any way, locked or not, answers with `rsp_way` = `whit_way`, `rsp_wr_en` = 1 and `rsp_victim` = 0, and changes no valid bit or pointer.
- R10: A command clears the named line and answers with `rsp_way` = `cmd_way` and `rsp_wr_en` = 0. For an invalidate (`cmd_push` = 0), `rsp_victim` = 0. For a push (`cmd_push` = 1), `rsp_victim` equals the line's prior valid bit.
- R11: `lock_en` is sampled in the cycle the allocate is accepted, so a change applies from the next allocate onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_en | input | 1 | Fences ways 0 and 1 from allocation |
| alloc_req | input | 1 | Allocate request |
| alloc_set | input | SET_BITS | Set index for allocation |
| whit_req | input | 1 | Write-hit update request |
| whit_way | input | 2 | Way that hit |
| cmd_req | input | 1 | Explicit line-removal command |
| cmd_push | input | 1 | 1 = push, 0 = invalidate |
| cmd_set | input | SET_BITS | Set named by the command |
| cmd_way | input | 2 | Way named by the command |
| rsp_vld | output | 1 | Response valid |
| rsp_way | output | 2 | Chosen way |
| rsp_wr_en | output | 1 | Data array write enable |
| rsp_victim | output | 1 | Old line must be pushed first |

## Verification
The hardest state to reach is a locked set in which both upper ways are valid while a lower way is still empty. This exposes any fallback to the lowest invalid way. A second hard state is when the toggle and the rotation pointer of the same set have both moved away from zero. The stimulus fills a fresh set under lock, so ways 0 and 1 stay empty, and cycles it several times. It also fills a set fully while unlocked and rotates it before locking it. A mid-sequence invalidate of way 2 then checks that the fill order restarts at way 2.

// File: rtl/lvs_pkg.sv
package lvs_pkg;
  localparam int WAY_CNT = 4;
  typedef logic [1:0] way_t;
  typedef logic [WAY_CNT-1:0] row_t;

  // {found, way}: lowest-numbered clear bit
  function automatic logic [2:0] lowest_free(row_t v);
    logic [2:0] r;
    r = 3'b000;
    for (int i = WAY_CNT - 1; i >= 0; i--)
      if (!v[i]) r = {1'b1, 2'(i)};
    return r;
  endfunction

  function automatic way_t choose_way(logic lk, row_t v, way_t rr, logic tg);
    logic [2:0] ff;
    ff = lowest_free(v);
    if (lk) begin
      if (!v[2])      return 2'd2;
      else if (!v[3]) return 2'd3;
      else            return {1'b1, tg};
    end
    return ff[2] ? ff[1:0] : rr;
  endfunction
endpackage

// File: rtl/lvs_state.sv
module lvs_state
  import lvs_pkg::*;
#(
  parameter int SETS = 16,
  localparam int SB = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SB-1:0] rd_set,
  output row_t          rd_valid,
  output way_t          rd_rr,
  output logic          rd_tg,
  input  logic          wr_en,
  input  logic [SB-1:0] wr_set,
  input  way_t          wr_way,
  input  logic          wr_val,
  input  logic          rr_adv,
  input  logic          tg_flip
);
  row_t valid_q [SETS];
  way_t rr_q    [SETS];
  logic tg_q    [SETS];

  assign rd_valid = valid_q[rd_set];
  assign rd_rr    = rr_q[rd_set];
  assign rd_tg    = tg_q[rd_set];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
        tg_q[s]    <= 1'b0;
      end
    end else begin
      if (wr_en)   valid_q[wr_set][wr_way] <= wr_val;
      if (rr_adv)  rr_q[wr_set] <= rr_q[wr_set] + 2'd1;
      if (tg_flip) tg_q[wr_set] <= ~tg_q[wr_set];
    end
  end
endmodule

// File: rtl/lvs_pick.sv
module lvs_pick
  import lvs_pkg::*;
(
  input  logic lock,
  input  row_t row,
  input  way_t rr,
  input  logic tg,
  output way_t way,
  output logic victim,
  output logic rr_adv,
  output logic tg_flip
);
  assign way     = choose_way(lock, row, rr, tg);
  assign victim  = row[way];
  assign rr_adv  = !lock && (&row);
  assign tg_flip = lock && row[2] && row[3];
endmodule

// File: rtl/lock_victim_sel.sv
module lock_victim_sel
  import lvs_pkg::*;
#(
  parameter int SETS = 16,
  localparam int SET_BITS = $clog2(SETS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lock_en,
  input  logic                alloc_req,
  input  logic [SET_BITS-1:0] alloc_set,
  input  logic                whit_req,
  input  logic [1:0]          whit_way,
  input  logic                cmd_req,
  input  logic                cmd_push,
  input  logic [SET_BITS-1:0] cmd_set,
  input  logic [1:0]          cmd_way,
  output logic                rsp_vld,
  output logic [1:0]          rsp_way,
  output logic                rsp_wr_en,
  output logic                rsp_victim
);
  // named events for the checker
  logic ev_cmd, ev_whit, ev_alloc;
  assign ev_cmd   = cmd_req;
  assign ev_whit  = whit_req && !cmd_req;
  assign ev_alloc = alloc_req && !cmd_req && !whit_req;

  logic [SET_BITS-1:0] rd_set;
  row_t row_valid;
  way_t row_rr, pick_way;
  logic row_tg, pick_victim, pick_rr_adv, pick_tg_flip;

  assign rd_set = ev_cmd ? cmd_set : alloc_set;

  lvs_pick u_pick (
    .lock(lock_en), .row(row_valid), .rr(row_rr), .tg(row_tg),
    .way(pick_way), .victim(pick_victim),
    .rr_adv(pick_rr_adv), .tg_flip(pick_tg_flip)
  );

  logic st_wr, st_val;
  way_t st_way;
  assign st_wr  = ev_cmd || ev_alloc;
  assign st_way = ev_cmd ? cmd_way : pick_way;
  assign st_val = !ev_cmd;

  lvs_state #(.SETS(SETS)) u_state (
    .clk(clk), .rst(rst), .rd_set(rd_set),
    .rd_valid(row_valid), .rd_rr(row_rr), .rd_tg(row_tg),
    .wr_en(st_wr), .wr_set(rd_set), .wr_way(st_way), .wr_val(st_val),
    .rr_adv(ev_alloc && pick_rr_adv), .tg_flip(ev_alloc && pick_tg_flip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld    <= 1'b0;
      rsp_way    <= '0;
      rsp_wr_en  <= 1'b0;
      rsp_victim <= 1'b0;
    end else begin
      rsp_vld   <= ev_cmd || ev_whit || ev_alloc;
      rsp_wr_en <= ev_whit || ev_alloc;
      if (ev_cmd) begin
        rsp_way    <= cmd_way;
        rsp_victim <= cmd_push && row_valid[cmd_way];
      end else if (ev_whit) begin
        rsp_way    <= whit_way;
        rsp_victim <= 1'b0;
      end else begin
        rsp_way    <= pick_way;
        rsp_victim <= ev_alloc && pick_victim;
      end
    end
  end
endmodule

// File: rtl/lvs_chk.sv
module lvs_chk (
  input logic       clk,
  input logic       rst,
  input logic       lock_en,
  input logic       ev_cmd,
  input logic       ev_whit,
  input logic       ev_alloc,
  input logic [3:0] row_valid,
  input logic [1:0] whit_way,
  input logic [1:0] cmd_way,
  input logic       rsp_vld,
  input logic [1:0] rsp_way,
  input logic       rsp_wr_en,
  input logic       rsp_victim
);
  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (ev_cmd || ev_whit || ev_alloc) |=> rsp_vld);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !(ev_cmd || ev_whit || ev_alloc) |=> !rsp_vld);
  assert_lock_fence_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_alloc && lock_en) |=> rsp_way[1]);
  assert_fill_way2_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_alloc && lock_en && !row_valid[2]) |=> (rsp_way == 2'd2));
  assert_full_victim_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_alloc && !lock_en && (row_valid == 4'hf)) |=> (rsp_victim && rsp_wr_en));
  assert_whit_resp_R9: assert property (@(posedge clk) disable iff (rst)
    ev_whit |=> (rsp_wr_en && !rsp_victim && rsp_way == $past(whit_way)));
  assert_cmd_resp_R10: assert property (@(posedge clk) disable iff (rst)
    ev_cmd |=> (!rsp_wr_en && rsp_way == $past(cmd_way)));
endmodule

bind lock_victim_sel lvs_chk u_chk (
  .clk(clk), .rst(rst), .lock_en(lock_en),
  .ev_cmd(ev_cmd), .ev_whit(ev_whit), .ev_alloc(ev_alloc),
  .row_valid(row_valid), .whit_way(whit_way), .cmd_way(cmd_way),
  .rsp_vld(rsp_vld), .rsp_way(rsp_way), .rsp_wr_en(rsp_wr_en),
  .rsp_victim(rsp_victim)
);

// File: tb/sim_lock_victim_sel.sv
module sim_lock_victim_sel;
  localparam int SETS = 16;
  localparam int SB = $clog2(SETS);

  logic clk = 1'b0, rst = 1'b1;
  logic lock_en = 0, alloc_req = 0, whit_req = 0, cmd_req = 0, cmd_push = 0;
  logic [SB-1:0] alloc_set = '0, cmd_set = '0;
  logic [1:0] whit_way = '0, cmd_way = '0;
  logic rsp_vld, rsp_wr_en, rsp_victim;
  logic [1:0] rsp_way;

  always #2 clk = ~clk;

  lock_victim_sel #(.SETS(SETS)) u0 (
    .clk(clk), .rst(rst), .lock_en(lock_en),
    .alloc_req(alloc_req), .alloc_set(alloc_set),
    .whit_req(whit_req), .whit_way(whit_way),
    .cmd_req(cmd_req), .cmd_push(cmd_push), .cmd_set(cmd_set), .cmd_way(cmd_way),
    .rsp_vld(rsp_vld), .rsp_way(rsp_way), .rsp_wr_en(rsp_wr_en), .rsp_victim(rsp_victim)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state, built from the requirements
  bit m_v [SETS][4];
  int m_rr [SETS];
  bit m_tg [SETS];

  int    q_way [$];
  bit    q_wr  [$];
  bit    q_vic [$];
  string q_tag [$];

  task automatic expect_item(int w, bit wr, bit vic, string tag);
    q_way.push_back(w); q_wr.push_back(wr); q_vic.push_back(vic); q_tag.push_back(tag);
  endtask

  // drive one cycle of requests and predict the response
  task automatic drive(bit c, bit p, int cs, int cw, bit h, int hw,
                       bit a, int as_, bit lk, string tag);
    @(negedge clk);
    cmd_req = c; cmd_push = p; cmd_set = SB'(cs); cmd_way = 2'(cw);
    whit_req = h; whit_way = 2'(hw);
    alloc_req = a; alloc_set = SB'(as_); lock_en = lk;
    if (c) begin
      expect_item(cw, 0, p && m_v[cs][cw], tag == "" ? "R10" : tag);
      m_v[cs][cw] = 0;
    end else if (h) begin
      expect_item(hw, 1, 0, tag == "" ? "R9" : tag);
    end else if (a) begin
      int w;
      string t;
      bit full;
      w = -1;
      full = 1;
      if (lk) begin
        if (!m_v[as_][2]) begin w = 2; t = "R6"; end
        else if (!m_v[as_][3]) begin w = 3; t = "R6"; end
        else begin w = 2 + int'(m_tg[as_]); m_tg[as_] = !m_tg[as_]; t = "R7"; end
      end else begin
        for (int i = 0; i < 4; i++)
          if (!m_v[as_][i]) full = 0;
        for (int i = 3; i >= 0; i--)
          if (!m_v[as_][i]) w = i;
        if (full) begin w = m_rr[as_]; m_rr[as_] = (m_rr[as_] + 1) % 4; t = "R4"; end
        else t = "R3";
      end
      expect_item(w, 1, m_v[as_][w], tag == "" ? t : tag);
      m_v[as_][w] = 1;
    end
    @(negedge clk);
    cmd_req = 0; whit_req = 0; alloc_req = 0;
  endtask

  task automatic alloc(int s, bit lk);
    drive(0, 0, 0, 0, 0, 0, 1, s, lk, "");
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_vld) begin
      checks++;
      if (q_way.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected response: actual vld=1 expected vld=0");
      end else begin
        int ew; bit ewr, evic; string et;
        ew = q_way.pop_front(); ewr = q_wr.pop_front();
        evic = q_vic.pop_front(); et = q_tag.pop_front();
        if (int'(rsp_way) != ew || rsp_wr_en != ewr || rsp_victim != evic) begin
          errors++;
          $display("FAIL %s actual way=%0d wr=%0d vic=%0d expected way=%0d wr=%0d vic=%0d",
                   et, rsp_way, rsp_wr_en, rsp_victim, ew, ewr, evic);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0; m_tg[s] = 0;
      for (int w = 0; w < 4; w++) m_v[s][w] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (rsp_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1 rsp_vld after reset actual %0d expected 0", rsp_vld);
    end
    // R1 R3 R8: empty set fills from way 0 upward
    for (int i = 0; i < 4; i++) alloc(0, 0);
    // R4: full set rotates through all ways
    for (int i = 0; i < 5; i++) alloc(0, 0);
    // R10: invalidate then lowest free way reused (R3)
    drive(1, 0, 0, 2, 0, 0, 0, 0, 0, "");
    alloc(0, 0);
    // R5 R6 R7: locked fill of an empty set keeps ways 0/1 empty
    for (int i = 0; i < 6; i++) alloc(1, 1);
    // R6: clear way 2 under lock, fill order restarts at way 2
    drive(1, 0, 1, 2, 0, 0, 0, 0, 0, "");
    alloc(1, 1);
    alloc(1, 1);
    // R7: locked allocation on a full, rotated set
    for (int i = 0; i < 3; i++) alloc(0, 1);
    // R9: write hits on fenced and open ways
    drive(0, 0, 0, 0, 1, 0, 0, 0, 1, "");
    drive(0, 0, 0, 0, 1, 1, 0, 0, 1, "");
    drive(0, 0, 0, 0, 1, 3, 0, 0, 0, "");
    // R10: push a valid line then push the now-empty line
    drive(1, 1, 0, 1, 0, 0, 0, 0, 1, "");
    drive(1, 1, 0, 1, 0, 0, 0, 0, 1, "");
    // R11: unlocking takes effect on the very next allocate (way 1 free)
    alloc(0, 0);
    // R2: command beats write hit and allocate in the same cycle
    drive(1, 1, 2, 3, 1, 2, 1, 2, 0, "R2");
    drive(0, 0, 0, 0, 1, 2, 1, 2, 0, "R2");
    alloc(2, 0);  // R2: set 2 still empty, dropped allocates left no trace
    // R11: lock raised on a set with ways 0/1 free
    alloc(3, 0);
    alloc(3, 1);
    repeat (3) @(negedge clk);
    checks++;
    if (q_way.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses actual %0d expected 0", q_way.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule